// File: doc/BRIEF.md
# Inclusion-Based Negative Snoop Filter

This block sits between the requesters of coherence invalidations and the snoop broadcast network. It holds a mirror of the tag array of an inclusive shared last-level cache. Each invalidation request is checked against that mirror. A miss shows that no private cache can hold the line, so the block drops the request and sends no snoop. A hit carries no information about which cores hold the line, so the block asks for a broadcast to every core. The filter can only rule cores out as a whole. It never names a subset of cores.

The mirror is kept in step with the shared cache by fill and evict updates. A fill that finds its set full replaces a way chosen round-robin for that set. Whenever a line leaves the mirror, whether by an explicit evict or by replacement, the block issues a back-invalidation of that line to all cores. This keeps inclusion intact. Two saturating counters record how many requests were dropped and how many were broadcast.

Addresses are line addresses. The low `log2(SETS)` bits select the set and the remaining upper bits form the tag. The decision leaves the block registered, one cycle after the request is accepted.

Top module: `incl_snoop_filter`

## Requirements
- R1: After reset, every mirror entry is invalid, `dec_valid_o` and `binv_valid_o` are low, both counters read zero, and `req_ready_o` is high while no update is presented.
- R2: An accepted request whose line is not in the mirror produces a decision with `dec_bcast_o` = 0, meaning the request is dropped.
- R3: An accepted request whose line is in the mirror produces a decision with `dec_bcast_o` = 1, meaning broadcast to all cores.
- R4: A request is accepted when `req_valid_i` and `req_ready_o` are both high. Exactly one cycle later `dec_valid_o` is high for one cycle and `dec_addr_o` echoes the request address. In cycles that follow no acceptance, `dec_valid_o` is low.
- R5: A fill (`upd_fill_i` = 1) of an absent line writes it into the lowest-numbered invalid way of its set. Lookups from the next cycle on hit that line. A fill of a line that is already present changes nothing and produces no back-invalidation.
- R6: A fill into a full set replaces the way named by that set's round-robin pointer. The pointer starts at way 0 and advances by one, wrapping after the last way, on each replacement in that set only. One cycle after the fill, `binv_valid_o` pulses with `binv_addr_o` set to the victim line address.
- R7: An evict (`upd_fill_i` = 0) of a present line invalidates it, and one cycle later `binv_valid_o` pulses with that line address. An evict of an absent line changes nothing and produces no back-invalidation.
- R8: While an update is presented to the same set as the request, `req_ready_o` is low and the request is not accepted. An update to a different set does not lower `req_ready_o`.
- R9: `drop_cnt_o` increments on each drop decision and `bcast_cnt_o` increments on each broadcast decision. Both update in the same cycle the decision appears, and both stay at all ones once they reach it.
- R10: Sets are independent. Updates in one set never change lookups or replacement order in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Invalidation request present |
| req_ready_o | output | 1 | Request may be accepted this cycle |
| req_addr_i | input | LA_W | Request line address |
| upd_valid_i | input | 1 | Mirror update present, always taken |
| upd_fill_i | input | 1 | 1 = fill (install), 0 = evict (remove) |
| upd_addr_i | input | LA_W | Update line address |
| dec_valid_o | output | 1 | Registered decision present |
| dec_bcast_o | output | 1 | 1 = broadcast to all cores, 0 = drop |
| dec_addr_o | output | LA_W | Address the decision refers to |
| binv_valid_o | output | 1 | Back-invalidation to all cores |
| binv_addr_o | output | LA_W | Line address to back-invalidate |
| drop_cnt_o | output | CNT_W | Saturating count of dropped requests |
| bcast_cnt_o | output | CNT_W | Saturating count of broadcast requests |

## Verification
A corrupted valid bit or tag shows up on the next lookup of that line as a flipped `dec_bcast_o`, and one counter drifts from its expected value from that cycle on. A wrong round-robin pointer cannot be seen until the set is full. It then shows as a wrong `binv_addr_o` on the next fill, one cycle after that fill, and later as a wrong hit or miss on the line that should have survived. Updates that target the request's set test the stall path, so a read-during-write error appears as an unexpected `req_ready_o` or as a stale decision in the cycle right after.

// File: rtl/snf_pkg.sv
package snf_pkg;
  typedef enum logic {
    UPD_EVICT = 1'b0,
    UPD_FILL  = 1'b1
  } upd_kind_e;
endpackage

// File: rtl/snf_way_match.sv
module snf_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 20,
  parameter int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = vld_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |eq;

  // at most one way can match, so any encoder order is fine
  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (eq[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/snf_sat_cnt.sv
module snf_sat_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/snf_tag_array.sv
module snf_tag_array
  import snf_pkg::*;
#(
  parameter int unsigned SETS  = 64,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 20,
  parameter int unsigned SET_W = $clog2(SETS),
  parameter int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SET_W-1:0]           rd_set_i,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tags_o,
  output logic [WAYS-1:0]            rd_vld_o,
  input  logic                       upd_valid_i,
  input  upd_kind_e                  upd_kind_i,
  input  logic [SET_W-1:0]           upd_set_i,
  input  logic [TAG_W-1:0]           upd_tag_i,
  output logic                       binv_valid_o,
  output logic [TAG_W+SET_W-1:0]     binv_addr_o
);
  localparam int unsigned LA_W = TAG_W + SET_W;

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0]            vld_q;
  logic [SETS-1:0][WAY_W-1:0]           rr_q;
  logic                                 binv_valid_q;
  logic [LA_W-1:0]                      binv_addr_q;

  logic [WAYS-1:0][TAG_W-1:0] u_tags;
  logic [WAYS-1:0]            u_vld;
  logic                       u_hit;
  logic [WAY_W-1:0]           u_way;
  logic                       free_any;
  logic [WAY_W-1:0]           free_way;
  logic [WAY_W-1:0]           victim;
  logic [WAY_W-1:0]           victim_nxt;

  assign rd_tags_o = tag_q[rd_set_i];
  assign rd_vld_o  = vld_q[rd_set_i];
  assign u_tags    = tag_q[upd_set_i];
  assign u_vld     = vld_q[upd_set_i];
  assign victim    = rr_q[upd_set_i];

  snf_way_match #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .WAY_W(WAY_W)
  ) u_upd_match (
    .tags_i(u_tags),
    .vld_i (u_vld),
    .tag_i (upd_tag_i),
    .hit_o (u_hit),
    .way_o (u_way)
  );

  // lowest invalid way wins
  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!u_vld[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign victim_nxt = (victim == WAY_W'(WAYS - 1)) ? '0 : victim + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q        <= '0;
      vld_q        <= '0;
      rr_q         <= '0;
      binv_valid_q <= 1'b0;
      binv_addr_q  <= '0;
    end else begin
      binv_valid_q <= 1'b0;
      if (upd_valid_i) begin
        if (upd_kind_i == UPD_FILL && !u_hit) begin
          if (free_any) begin
            tag_q[upd_set_i][free_way] <= upd_tag_i;
            vld_q[upd_set_i][free_way] <= 1'b1;
          end else begin
            // replace and back-invalidate the victim in the same step
            tag_q[upd_set_i][victim] <= upd_tag_i;
            rr_q[upd_set_i]          <= victim_nxt;
            binv_valid_q             <= 1'b1;
            binv_addr_q              <= {u_tags[victim], upd_set_i};
          end
        end else if (upd_kind_i == UPD_EVICT && u_hit) begin
          vld_q[upd_set_i][u_way] <= 1'b0;
          binv_valid_q            <= 1'b1;
          binv_addr_q             <= {upd_tag_i, upd_set_i};
        end
      end
    end
  end

  assign binv_valid_o = binv_valid_q;
  assign binv_addr_o  = binv_addr_q;
endmodule

// File: rtl/incl_snoop_filter.sv
module incl_snoop_filter
  import snf_pkg::*;
#(
  parameter int unsigned LA_W  = 26,
  parameter int unsigned SETS  = 64,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [LA_W-1:0]  req_addr_i,
  input  logic             upd_valid_i,
  input  logic             upd_fill_i,
  input  logic [LA_W-1:0]  upd_addr_i,
  output logic             dec_valid_o,
  output logic             dec_bcast_o,
  output logic [LA_W-1:0]  dec_addr_o,
  output logic             binv_valid_o,
  output logic [LA_W-1:0]  binv_addr_o,
  output logic [CNT_W-1:0] drop_cnt_o,
  output logic [CNT_W-1:0] bcast_cnt_o
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned TAG_W = LA_W - SET_W;

  logic [SET_W-1:0]           req_set;
  logic [TAG_W-1:0]           req_tag;
  logic [SET_W-1:0]           upd_set;
  logic [TAG_W-1:0]           upd_tag;
  logic [WAYS-1:0][TAG_W-1:0] rd_tags;
  logic [WAYS-1:0]            rd_vld;
  logic                       lk_hit;
  logic [WAY_W-1:0]           lk_way;
  logic                       accept;
  upd_kind_e                  upd_kind;

  logic            dec_valid_q;
  logic            dec_bcast_q;
  logic [LA_W-1:0] dec_addr_q;

  assign req_set  = req_addr_i[SET_W-1:0];
  assign req_tag  = req_addr_i[LA_W-1:SET_W];
  assign upd_set  = upd_addr_i[SET_W-1:0];
  assign upd_tag  = upd_addr_i[LA_W-1:SET_W];
  assign upd_kind = upd_fill_i ? UPD_FILL : UPD_EVICT;

  // same-set update wins; the request retries next cycle
  assign req_ready_o = !(upd_valid_i && (upd_set == req_set));
  assign accept      = req_valid_i && req_ready_o;

  snf_tag_array #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .SET_W(SET_W),
    .WAY_W(WAY_W)
  ) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_set_i    (req_set),
    .rd_tags_o   (rd_tags),
    .rd_vld_o    (rd_vld),
    .upd_valid_i (upd_valid_i),
    .upd_kind_i  (upd_kind),
    .upd_set_i   (upd_set),
    .upd_tag_i   (upd_tag),
    .binv_valid_o(binv_valid_o),
    .binv_addr_o (binv_addr_o)
  );

  snf_way_match #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .WAY_W(WAY_W)
  ) u_lk_match (
    .tags_i(rd_tags),
    .vld_i (rd_vld),
    .tag_i (req_tag),
    .hit_o (lk_hit),
    .way_o (lk_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_q <= 1'b0;
      dec_bcast_q <= 1'b0;
      dec_addr_q  <= '0;
    end else begin
      dec_valid_q <= accept;
      if (accept) begin
        dec_bcast_q <= lk_hit;
        dec_addr_q  <= req_addr_i;
      end
    end
  end

  snf_sat_cnt #(.CNT_W(CNT_W)) u_drop_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (accept && !lk_hit),
    .cnt_o (drop_cnt_o)
  );

  snf_sat_cnt #(.CNT_W(CNT_W)) u_bcast_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (accept && lk_hit),
    .cnt_o (bcast_cnt_o)
  );

  assign dec_valid_o = dec_valid_q;
  assign dec_bcast_o = dec_bcast_q;
  assign dec_addr_o  = dec_addr_q;

  logic unused_way;
  assign unused_way = ^lk_way;
endmodule

// File: rtl/snf_checker.sv
module snf_checker #(
  parameter int unsigned LA_W  = 26,
  parameter int unsigned SETS  = 64,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [LA_W-1:0]  req_addr_i,
  input logic             upd_valid_i,
  input logic [LA_W-1:0]  upd_addr_i,
  input logic             dec_valid_o,
  input logic [LA_W-1:0]  dec_addr_o,
  input logic             binv_valid_o,
  input logic [CNT_W-1:0] drop_cnt_o,
  input logic [CNT_W-1:0] bcast_cnt_o
);
  localparam int unsigned SET_W = $clog2(SETS);

  logic same_set;
  assign same_set = req_addr_i[SET_W-1:0] == upd_addr_i[SET_W-1:0];

  a_r4_accept_gives_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> dec_valid_o);

  a_r4_idle_no_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !dec_valid_o);

  a_r4_addr_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (dec_addr_o == $past(req_addr_i)));

  a_r8_same_set_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && same_set) |-> !req_ready_o);

  a_r8_no_needless_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |-> req_ready_o);

  a_r7_binv_needs_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> !binv_valid_o);

  a_r9_drop_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drop_cnt_o >= $past(drop_cnt_o)));

  a_r9_bcast_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (bcast_cnt_o >= $past(bcast_cnt_o)));

  a_r9_cnt_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> ($stable(drop_cnt_o) && $stable(bcast_cnt_o)));
endmodule

bind incl_snoop_filter snf_checker #(
  .LA_W (LA_W),
  .SETS (SETS),
  .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .upd_valid_i (upd_valid_i),
  .upd_addr_i  (upd_addr_i),
  .dec_valid_o (dec_valid_o),
  .dec_addr_o  (dec_addr_o),
  .binv_valid_o(binv_valid_o),
  .drop_cnt_o  (drop_cnt_o),
  .bcast_cnt_o (bcast_cnt_o)
);

// File: tb/incl_snoop_filter_bench.sv
module incl_snoop_filter_bench;
  localparam int LA_W  = 26;
  localparam int SETS  = 64;
  localparam int WAYS  = 4;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             req_valid, req_ready, upd_valid, upd_fill;
  logic [LA_W-1:0]  req_addr, upd_addr;
  logic             dec_valid, dec_bcast, binv_valid;
  logic [LA_W-1:0]  dec_addr, binv_addr;
  logic [CNT_W-1:0] drop_cnt, bcast_cnt;

  incl_snoop_filter #(.LA_W(LA_W), .SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) u_incl_snoop_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .upd_valid_i(upd_valid), .upd_fill_i(upd_fill), .upd_addr_i(upd_addr),
    .dec_valid_o(dec_valid), .dec_bcast_o(dec_bcast), .dec_addr_o(dec_addr),
    .binv_valid_o(binv_valid), .binv_addr_o(binv_addr),
    .drop_cnt_o(drop_cnt), .bcast_cnt_o(bcast_cnt)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model: per set, a slot list and a replacement pointer
  int m_tag [SETS][WAYS];
  bit m_vld [SETS][WAYS];
  int m_rr  [SETS];
  int e_dc = 0, e_bcc = 0;
  bit e_dv = 0, e_bc = 0, e_bv = 0;
  int e_da = 0, e_ba = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int find(input int la);
    int s = la % SETS;
    int t = la / SETS;
    for (int w = 0; w < WAYS; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic compare_outputs();
    chk(dec_valid == e_dv, "R4 dec_valid", int'(dec_valid), int'(e_dv));
    if (e_dv) begin
      chk(dec_bcast == e_bc, e_bc ? "R3 broadcast on hit" : "R2 drop on miss",
          int'(dec_bcast), int'(e_bc));
      chk(int'(dec_addr) == e_da, "R4 dec_addr", int'(dec_addr), e_da);
    end
    chk(binv_valid == e_bv, "R6/R7 binv_valid", int'(binv_valid), int'(e_bv));
    if (e_bv) chk(int'(binv_addr) == e_ba, "R6/R7 binv_addr", int'(binv_addr), e_ba);
    chk(int'(drop_cnt) == e_dc, "R9 drop count", int'(drop_cnt), e_dc);
    chk(int'(bcast_cnt) == e_bcc, "R9 bcast count", int'(bcast_cnt), e_bcc);
  endtask

  // called at the negative edge: drive, predict, clock, compare
  task automatic step(input bit rv, input int ra, input bit uv, input bit uf, input int ua);
    bit rdy, acc;
    int s, w, fw;
    req_valid = rv; req_addr = LA_W'(ra);
    upd_valid = uv; upd_fill = uf; upd_addr = LA_W'(ua);
    #1;
    rdy = !(uv && (ra % SETS) == (ua % SETS));
    chk(req_ready == rdy, "R8 req_ready", int'(req_ready), int'(rdy));
    acc = rv && rdy;
    e_dv = acc;
    if (acc) begin
      e_bc = find(ra) >= 0;
      e_da = ra;
      if (e_bc) begin if (e_bcc < CMAX) e_bcc++; end
      else begin if (e_dc < CMAX) e_dc++; end
    end
    e_bv = 0;
    if (uv) begin
      s = ua % SETS;
      w = find(ua);
      if (uf && w < 0) begin
        fw = -1;
        for (int k = WAYS - 1; k >= 0; k--) if (!m_vld[s][k]) fw = k;
        if (fw >= 0) begin
          m_tag[s][fw] = ua / SETS; m_vld[s][fw] = 1;
        end else begin
          e_bv = 1; e_ba = m_tag[s][m_rr[s]] * SETS + s;
          m_tag[s][m_rr[s]] = ua / SETS;
          m_rr[s] = (m_rr[s] + 1) % WAYS;
        end
      end else if (!uf && w >= 0) begin
        m_vld[s][w] = 0; e_bv = 1; e_ba = ua;
      end
    end
    @(posedge clk); #1;
    compare_outputs();
    @(negedge clk);
  endtask

  function automatic int la(input int tag, input int set);
    return tag * SETS + set;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin m_vld[s][w] = 0; m_tag[s][w] = 0; end
    end
    req_valid = 0; req_addr = '0; upd_valid = 0; upd_fill = 0; upd_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!dec_valid && !binv_valid, "R1 outputs idle in reset", int'(dec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_outputs();
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // R2: empty mirror drops everything
    for (int i = 0; i < 6; i++) step(1, la(i + 3, i * 9), 0, 0, 0);
    // R5: install then hit; duplicate fill is silent
    step(0, 0, 1, 1, la(17, 5));
    step(1, la(17, 5), 0, 0, 0);
    step(1, la(18, 5), 1, 1, la(17, 5));  // R8 stalled, same set
    step(1, la(17, 5), 1, 1, la(17, 6));  // R8 other set accepted, R3 hit
    // R6: fill set 7 past capacity, round-robin victims
    for (int t = 1; t <= 6; t++) step(0, 0, 1, 1, la(t, 7));
    step(1, la(1, 7), 0, 0, 0);
    step(1, la(2, 7), 0, 0, 0);
    step(1, la(3, 7), 0, 0, 0);
    step(1, la(6, 7), 0, 0, 0);
    // R7: evict present, then absent
    step(0, 0, 1, 0, la(4, 7));
    step(0, 0, 1, 0, la(4, 7));
    step(1, la(4, 7), 0, 0, 0);
    step(0, 0, 1, 1, la(9, 7));           // R5 fills the hole, no binv
    step(0, 0, 1, 1, la(10, 7));          // R6 resumes at pointer way 2
    // R10: set 5 untouched by set 7 traffic
    step(1, la(17, 5), 0, 0, 0);
    // mixed traffic over a small pool to force hits, stalls and replacements
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) != 0, la($urandom_range(0, 5), $urandom_range(0, 3)),
           $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0,
           la($urandom_range(0, 5), $urandom_range(0, 3)));
    end
    // R9: both counters pinned at all ones
    for (int i = 0; i < 20; i++) step(1, la(40 + i, 50), 0, 0, 0);
    step(0, 0, 1, 1, la(1, 51));
    for (int i = 0; i < 20; i++) step(1, la(1, 51), 0, 0, 0);
    chk(int'(drop_cnt) == CMAX, "R9 drop saturates", int'(drop_cnt), CMAX);
    chk(int'(bcast_cnt) == CMAX, "R9 bcast saturates", int'(bcast_cnt), CMAX);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule